// File: doc/BRIEF.md
# Integer Execute Unit with Barrel Shifter

A purely combinational execute stage for a 32-bit load/store integer pipeline. Each cycle it takes a decoded instruction's primary opcode and function code, the two source register values and the instruction's shift-distance and 16-bit immediate fields. It returns the value to write back, a signed-overflow flag, a write-enable and an illegal-instruction flag.

Register-register forms (primary opcode 0) choose their operation from the function code. Immediate forms replace the second operand with an extended immediate. A single adder serves checked and unchecked addition, subtraction and both less-than compares. A logarithmic shifter serves left, logical-right and arithmetic-right shifts. The shift distance comes either from the instruction field or from the low bits of the first register operand.

Top module: `alu_exec`

## Requirements
- R1: With opcode 0, function codes 32 and 33 return rs+rt and codes 34 and 35 return rs-rt, each wrapped modulo 2^32.
- R2: With opcode 0, function codes 36, 37, 38 and 39 return the bitwise AND, OR, XOR and NOR of rs and rt.
- R3: Function codes 32 and 34 and opcode 8 raise ovf_o and drop wr_en_o on two's-complement overflow, while still returning the wrapped value. Function codes 33 and 35 and opcode 9 never raise ovf_o.
- R4: Function code 42 returns 1 when rs < rt as signed numbers and 0 otherwise. Function code 43 does the same comparison as unsigned numbers.
- R5: Function codes 0 (left), 2 (logical right) and 3 (arithmetic right) shift rt by shamt_i, and rs has no effect on them.
- R6: Function codes 4 (left), 6 (logical right) and 7 (arithmetic right) shift rt by the low 5 bits of rs, and shamt_i has no effect on them.
- R7: Arithmetic right shifts fill the vacated bits with copies of bit 31. Logical shifts fill them with zeros.
- R8: Opcode 8 and opcode 9 return rs plus the sign-extended immediate.
- R9: Opcode 10 returns 1 when rs is less than the sign-extended immediate as signed numbers. Opcode 11 compares rs with the sign-extended immediate as unsigned numbers.
- R10: Opcodes 12, 13 and 14 return the AND, OR and XOR of rs with the zero-extended immediate.
- R11: Opcode 15 returns the immediate in bits 31:16 with bits 15:0 zero, whatever rs holds.
- R12: Any other opcode, or any function code not listed above under opcode 0, raises illegal_o and returns result 0 with ovf_o and wr_en_o low.
- R13: Every recognised operation that does not overflow raises wr_en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Primary opcode |
| funct_i | input | 6 | Function code, used when opcode is 0 |
| rs_i | input | 32 | First register operand |
| rt_i | input | 32 | Second register operand, and the value shifted |
| shamt_i | input | 5 | Shift distance field of the instruction |
| imm_i | input | 16 | Immediate field of the instruction |
| result_o | output | 32 | Write-back value |
| ovf_o | output | 1 | Signed overflow on a checked add or subtract |
| wr_en_o | output | 1 | Result may be written to the destination |
| illegal_o | output | 1 | Opcode or function code not recognised |

## Verification
The in-line checks assume every input is driven to a defined 0/1 value at the moment they are evaluated. They are exercised only with settled operands, because the block has no clock of its own. The bench changes all inputs together on the falling clock edge and reads the outputs one time unit after the next rising edge. No check ever sees a half-applied instruction.

The operand values are chosen at the points where the flags change. These include the largest positive number plus one and the most negative number minus one. They also include equal operands, immediates with bit 15 set, and register shift distances with the upper bits of rs set.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OPC_W = 6;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR,
    OP_SLT, OP_SLTU, OP_SLL, OP_SRL, OP_SRA, OP_LUI, OP_BAD
  } op_e;

  typedef struct packed {
    op_e  op;
    logic use_imm;  // second operand from immediate
    logic sext;     // immediate sign-extended
    logic chk_ovf;  // overflow suppresses write
    logic var_sh;   // distance from rs
    logic legal;
  } dec_t;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [OPC_W-1:0] funct_i,
  output dec_t             dec_o
);
  always_comb begin
    dec_o = '{op: OP_BAD, use_imm: 1'b0, sext: 1'b0, chk_ovf: 1'b0,
              var_sh: 1'b0, legal: 1'b1};
    if (opcode_i == '0) begin
      unique case (funct_i)
        6'd0:  dec_o.op = OP_SLL;
        6'd2:  dec_o.op = OP_SRL;
        6'd3:  dec_o.op = OP_SRA;
        6'd4:  begin dec_o.op = OP_SLL; dec_o.var_sh = 1'b1; end
        6'd6:  begin dec_o.op = OP_SRL; dec_o.var_sh = 1'b1; end
        6'd7:  begin dec_o.op = OP_SRA; dec_o.var_sh = 1'b1; end
        6'd32: begin dec_o.op = OP_ADD; dec_o.chk_ovf = 1'b1; end
        6'd33: dec_o.op = OP_ADD;
        6'd34: begin dec_o.op = OP_SUB; dec_o.chk_ovf = 1'b1; end
        6'd35: dec_o.op = OP_SUB;
        6'd36: dec_o.op = OP_AND;
        6'd37: dec_o.op = OP_OR;
        6'd38: dec_o.op = OP_XOR;
        6'd39: dec_o.op = OP_NOR;
        6'd42: dec_o.op = OP_SLT;
        6'd43: dec_o.op = OP_SLTU;
        default: dec_o.legal = 1'b0;
      endcase
    end else begin
      dec_o.use_imm = 1'b1;
      unique case (opcode_i)
        6'd8:  begin dec_o.op = OP_ADD; dec_o.sext = 1'b1; dec_o.chk_ovf = 1'b1; end
        6'd9:  begin dec_o.op = OP_ADD; dec_o.sext = 1'b1; end
        6'd10: begin dec_o.op = OP_SLT; dec_o.sext = 1'b1; end
        6'd11: begin dec_o.op = OP_SLTU; dec_o.sext = 1'b1; end
        6'd12: dec_o.op = OP_AND;
        6'd13: dec_o.op = OP_OR;
        6'd14: dec_o.op = OP_XOR;
        6'd15: dec_o.op = OP_LUI;
        default: dec_o.legal = 1'b0;
      endcase
    end
    if (!dec_o.legal) dec_o.op = OP_BAD;
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              ovf_o,
  output logic              lt_s_o,  // valid when sub_i
  output logic              lt_u_o   // valid when sub_i
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   full;

  always_comb begin
    b_eff  = sub_i ? ~b_i : b_i;
    full   = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
    sum_o  = full[MSB:0];
    ovf_o  = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
    lt_u_o = ~full[DATA_W];
    lt_s_o = (a_i[MSB] != b_i[MSB]) ? a_i[MSB] : sum_o[MSB];
  end

  // R4: equal operands never compare less
  always_comb begin
    if (sub_i && a_i == b_i) begin
      p_eq_not_less_r4: assert (!lt_s_o && !lt_u_o);
    end
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [SH_W-1:0]   dist_i,
  input  logic              left_i,
  input  logic              arith_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] src, rev_out;
  logic [DATA_W-1:0] stage [SH_W+1];
  logic              fill;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) src[i] = left_i ? val_i[DATA_W-1-i] : val_i[i];
    fill = arith_i & ~left_i & val_i[DATA_W-1];
  end

  assign stage[0] = src;

  // Right-shift ladder; left shifts run through it bit-reversed
  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = dist_i[k] ? {{STEP{fill}}, stage[k][DATA_W-1:STEP]} : stage[k];
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++) rev_out[i] = stage[SH_W][DATA_W-1-i];
    res_o = left_i ? rev_out : stage[SH_W];
  end

  always_comb begin
    if (dist_i == '0) begin
      p_zero_dist_r5: assert (res_o == val_i);
    end
    if (!left_i && arith_i) begin
      p_sign_fill_r7: assert (res_o[DATA_W-1] == val_i[DATA_W-1]);
    end
  end
endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [OPC_W-1:0]  funct_i,
  input  logic [DATA_W-1:0] rs_i,
  input  logic [DATA_W-1:0] rt_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] result_o,
  output logic              ovf_o,
  output logic              wr_en_o,
  output logic              illegal_o
);
  localparam int EXT_W = DATA_W - IMM_W;

  dec_t              dec;
  logic [DATA_W-1:0] imm_ext, opnd_b, sum, sh_res;
  logic [SH_W-1:0]   sh_dist;
  logic              is_sub, ovf_raw, lt_s, lt_u;

  alu_decode u_dec (
    .opcode_i (opcode_i),
    .funct_i  (funct_i),
    .dec_o    (dec)
  );

  always_comb begin
    imm_ext = {{EXT_W{dec.sext & imm_i[IMM_W-1]}}, imm_i};
    opnd_b  = dec.use_imm ? imm_ext : rt_i;
    is_sub  = dec.op inside {OP_SUB, OP_SLT, OP_SLTU};
    sh_dist = dec.var_sh ? rs_i[SH_W-1:0] : shamt_i;
  end

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i    (rs_i),
    .b_i    (opnd_b),
    .sub_i  (is_sub),
    .sum_o  (sum),
    .ovf_o  (ovf_raw),
    .lt_s_o (lt_s),
    .lt_u_o (lt_u)
  );

  alu_shift #(.DATA_W(DATA_W)) u_shift (
    .val_i   (rt_i),
    .dist_i  (sh_dist),
    .left_i  (dec.op == OP_SLL),
    .arith_i (dec.op == OP_SRA),
    .res_o   (sh_res)
  );

  always_comb begin
    unique case (dec.op)
      OP_ADD, OP_SUB:          result_o = sum;
      OP_AND:                  result_o = rs_i & opnd_b;
      OP_OR:                   result_o = rs_i | opnd_b;
      OP_XOR:                  result_o = rs_i ^ opnd_b;
      OP_NOR:                  result_o = ~(rs_i | opnd_b);
      OP_SLT:                  result_o = {{(DATA_W-1){1'b0}}, lt_s};
      OP_SLTU:                 result_o = {{(DATA_W-1){1'b0}}, lt_u};
      OP_SLL, OP_SRL, OP_SRA:  result_o = sh_res;
      OP_LUI:                  result_o = {imm_i, {EXT_W{1'b0}}};
      default:                 result_o = '0;
    endcase
    illegal_o = ~dec.legal;
    ovf_o     = dec.legal & dec.chk_ovf & ovf_raw;
    wr_en_o   = dec.legal & ~ovf_o;
  end

  always_comb begin
    p_ovf_blocks_wr_r3: assert (!(ovf_o && wr_en_o));
    if (illegal_o) begin
      p_illegal_quiet_r12: assert (!wr_en_o && !ovf_o && result_o == '0);
    end
    if ((opcode_i == 6'd0 && (funct_i == 6'd33 || funct_i == 6'd35)) || opcode_i == 6'd9) begin
      p_no_overflow_r3: assert (!ovf_o && wr_en_o);
    end
    if (opcode_i == 6'd0 && (funct_i == 6'd42 || funct_i == 6'd43)) begin
      p_slt_bool_r4: assert (result_o[DATA_W-1:1] == '0);
    end
    if (opcode_i == 6'd15) begin
      p_lui_low_zero_r11: assert (result_o[EXT_W-1:0] == '0 && wr_en_o);
    end
  end
endmodule

// File: tb/alu_exec_tb.sv
module alu_exec_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [5:0]  opc;
    logic [5:0]  fn;
    logic [31:0] rs;
    logic [31:0] rt;
    logic [4:0]  sh;
    logic [15:0] imm;
    logic [31:0] res;
    logic        ovf;
    logic        wr;
    logic        ill;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    '{6'd0, 6'd32, 32'h5, 32'h7, 5'd0, 16'hFFFF, 32'hC, 1'b0, 1'b1, 1'b0, 8'd1},               // R1
    '{6'd0, 6'd33, 32'hFFFFFFFF, 32'h1, 5'd0, 16'h0, 32'h0, 1'b0, 1'b1, 1'b0, 8'd1},          // R1
    '{6'd0, 6'd34, 32'h3, 32'h5, 5'd0, 16'h0, 32'hFFFFFFFE, 1'b0, 1'b1, 1'b0, 8'd1},          // R1
    '{6'd0, 6'd35, 32'h80000000, 32'h1, 5'd0, 16'h0, 32'h7FFFFFFF, 1'b0, 1'b1, 1'b0, 8'd3},   // R3
    '{6'd0, 6'd32, 32'h7FFFFFFF, 32'h1, 5'd0, 16'h0, 32'h80000000, 1'b1, 1'b0, 1'b0, 8'd3},   // R3
    '{6'd0, 6'd34, 32'h80000000, 32'h1, 5'd0, 16'h0, 32'h7FFFFFFF, 1'b1, 1'b0, 1'b0, 8'd3},   // R3
    '{6'd0, 6'd33, 32'h7FFFFFFF, 32'h1, 5'd0, 16'h0, 32'h80000000, 1'b0, 1'b1, 1'b0, 8'd3},   // R3
    '{6'd0, 6'd36, 32'hF0F0F0F0, 32'hFF00FF00, 5'd0, 16'h0, 32'hF000F000, 1'b0, 1'b1, 1'b0, 8'd2}, // R2
    '{6'd0, 6'd37, 32'hF0F0F0F0, 32'hFF00FF00, 5'd0, 16'h0, 32'hFFF0FFF0, 1'b0, 1'b1, 1'b0, 8'd2},
    '{6'd0, 6'd38, 32'hF0F0F0F0, 32'hFF00FF00, 5'd0, 16'h0, 32'h0FF00FF0, 1'b0, 1'b1, 1'b0, 8'd2},
    '{6'd0, 6'd39, 32'hF0F0F0F0, 32'hFF00FF00, 5'd0, 16'h0, 32'h000F000F, 1'b0, 1'b1, 1'b0, 8'd2},
    '{6'd0, 6'd42, 32'hFFFFFFFF, 32'h1, 5'd0, 16'h0, 32'h1, 1'b0, 1'b1, 1'b0, 8'd4},          // R4
    '{6'd0, 6'd43, 32'hFFFFFFFF, 32'h1, 5'd0, 16'h0, 32'h0, 1'b0, 1'b1, 1'b0, 8'd4},
    '{6'd0, 6'd42, 32'h5, 32'h5, 5'd0, 16'h0, 32'h0, 1'b0, 1'b1, 1'b0, 8'd4},
    '{6'd0, 6'd0, 32'hDEADBEEF, 32'h1, 5'd31, 16'h0, 32'h80000000, 1'b0, 1'b1, 1'b0, 8'd5},   // R5
    '{6'd0, 6'd2, 32'hFFFFFFFF, 32'h80000000, 5'd4, 16'h0, 32'h08000000, 1'b0, 1'b1, 1'b0, 8'd7}, // R7
    '{6'd0, 6'd3, 32'h0, 32'h80000000, 5'd4, 16'h0, 32'hF8000000, 1'b0, 1'b1, 1'b0, 8'd7},    // R7
    '{6'd0, 6'd3, 32'h0, 32'h7FFFFFFF, 5'd30, 16'h0, 32'h1, 1'b0, 1'b1, 1'b0, 8'd7},
    '{6'd0, 6'd4, 32'h24, 32'hF, 5'd0, 16'h0, 32'hF0, 1'b0, 1'b1, 1'b0, 8'd6},                // R6
    '{6'd0, 6'd6, 32'hFFFFFFE1, 32'hF0000000, 5'd9, 16'h0, 32'h78000000, 1'b0, 1'b1, 1'b0, 8'd6},
    '{6'd0, 6'd7, 32'h3F, 32'h80000000, 5'd0, 16'h0, 32'hFFFFFFFF, 1'b0, 1'b1, 1'b0, 8'd6},
    '{6'd8, 6'd0, 32'h10, 32'h0, 5'd0, 16'hFFFF, 32'hF, 1'b0, 1'b1, 1'b0, 8'd8},              // R8
    '{6'd8, 6'd0, 32'h7FFFFFFF, 32'h0, 5'd0, 16'h0001, 32'h80000000, 1'b1, 1'b0, 1'b0, 8'd3}, // R3
    '{6'd9, 6'd0, 32'h7FFFFFFF, 32'h0, 5'd0, 16'h0001, 32'h80000000, 1'b0, 1'b1, 1'b0, 8'd8}, // R8
    '{6'd10, 6'd0, 32'hFFFFFFFE, 32'h0, 5'd0, 16'hFFFF, 32'h1, 1'b0, 1'b1, 1'b0, 8'd9},       // R9
    '{6'd11, 6'd0, 32'h5, 32'h0, 5'd0, 16'hFFFF, 32'h1, 1'b0, 1'b1, 1'b0, 8'd9},
    '{6'd11, 6'd0, 32'hFFFFFFFF, 32'h0, 5'd0, 16'h8000, 32'h0, 1'b0, 1'b1, 1'b0, 8'd9},
    '{6'd12, 6'd0, 32'hFFFFFFFF, 32'h0, 5'd0, 16'h8001, 32'h00008001, 1'b0, 1'b1, 1'b0, 8'd10}, // R10
    '{6'd13, 6'd0, 32'h12340000, 32'h0, 5'd0, 16'h8000, 32'h12348000, 1'b0, 1'b1, 1'b0, 8'd10},
    '{6'd14, 6'd0, 32'hFFFF0000, 32'h0, 5'd0, 16'hFFFF, 32'hFFFFFFFF, 1'b0, 1'b1, 1'b0, 8'd10},
    '{6'd15, 6'd0, 32'hFFFFFFFF, 32'h0, 5'd0, 16'h1234, 32'h12340000, 1'b0, 1'b1, 1'b0, 8'd11}, // R11
    '{6'd0, 6'd1, 32'h5, 32'h7, 5'd3, 16'h0, 32'h0, 1'b0, 1'b0, 1'b1, 8'd12},                 // R12
    '{6'd0, 6'd40, 32'h7FFFFFFF, 32'h1, 5'd0, 16'h0, 32'h0, 1'b0, 1'b0, 1'b1, 8'd12},
    '{6'd2, 6'd32, 32'h5, 32'h7, 5'd0, 16'h1, 32'h0, 1'b0, 1'b0, 1'b1, 8'd12}
  };

  logic        clk = 1'b0;
  logic [5:0]  opcode, funct;
  logic [31:0] rs, rt, result;
  logic [4:0]  shamt;
  logic [15:0] imm;
  logic        ovf, wr_en, illegal;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_exec u_dut (
    .opcode_i  (opcode),
    .funct_i   (funct),
    .rs_i      (rs),
    .rt_i      (rt),
    .shamt_i   (shamt),
    .imm_i     (imm),
    .result_o  (result),
    .ovf_o     (ovf),
    .wr_en_o   (wr_en),
    .illegal_o (illegal)
  );

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    opcode = v.opc; funct = v.fn; rs = v.rs; rt = v.rt; shamt = v.sh; imm = v.imm;
    @(posedge clk);
    #1;
    checks++;
    if (result !== v.res || ovf !== v.ovf || wr_en !== v.wr || illegal !== v.ill) begin
      errors++;
      $display("FAIL R%0d op=%0d fn=%0d: got res=%h ovf=%b wr=%b ill=%b, expected res=%h ovf=%b wr=%b ill=%b",
               v.req, v.opc, v.fn, result, ovf, wr_en, illegal, v.res, v.ovf, v.wr, v.ill);
    end
  endtask

  initial begin
    opcode = '0; funct = '0; rs = '0; rt = '0; shamt = '0; imm = '0;
    // Idle inputs decode as a zero-distance left shift of zero (R5, R13)
    @(posedge clk);
    #1;
    checks++;
    if (result !== '0 || ovf !== 1'b0 || wr_en !== 1'b1 || illegal !== 1'b0) begin
      errors++;
      $display("FAIL R13 idle: got res=%h ovf=%b wr=%b ill=%b, expected res=0 ovf=0 wr=1 ill=0",
               result, ovf, wr_en, illegal);
    end

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R6: shamt field ignored by a variable shift, distance only from rs low bits
    run_vec('{6'd0, 6'd4, 32'hFFFFFFE0, 32'h1, 5'd31, 16'h0, 32'h1, 1'b0, 1'b1, 1'b0, 8'd6});
    // R5: rs ignored by a fixed shift, distance 0 passes rt through
    run_vec('{6'd0, 6'd2, 32'h1F, 32'hA5A5A5A5, 5'd0, 16'h0, 32'hA5A5A5A5, 1'b0, 1'b1, 1'b0, 8'd5});
    // R3: SUB of opposite-sign boundary without overflow
    run_vec('{6'd0, 6'd34, 32'hFFFFFFFF, 32'h7FFFFFFF, 5'd0, 16'h0, 32'h80000000, 1'b0, 1'b1, 1'b0, 8'd3});
    // R12: highest function code is not recognised
    run_vec('{6'd0, 6'd63, 32'h1, 32'h1, 5'd0, 16'h0, 32'h0, 1'b0, 1'b0, 1'b1, 8'd12});
    done = 1'b1;
  end

  initial begin : watchdog
    fork
      wait (done);
      begin
        repeat (10000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got hung run, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule